// File: doc/BRIEF.md
# Flash Power-Up Write-Inhibit Controller

This block supervises the supply sequence of a serial flash device model. Two digital comparator flags arrive from analog sensing: one says the supply is above the write-inhibit threshold, the other says it has reached the minimum operating level. While the first flag is low, every register of the block is held cleared and no instruction is acknowledged. Once it is high, two independent delay timers measure time from each crossing. Their lengths are parameters given in clock cycles. Read instructions are released after the operating-level delay. Write-enable and all modifying instructions (status write, program, erase) wait until both delays have expired.

The command engine presents one decoded instruction-class strobe per cycle. The block answers each strobe one cycle later with an accept or an ignore pulse. It also keeps the write-enable latch and the write-in-progress bit, and it tracks standby versus deep power-down. It issues a one-cycle pulse that loads the lock registers with write-lock = 0 and lock-down = 0. It raises a sticky flag when a program or erase is cut off by a power loss.

The controller has five states. OFF is held while the inhibit flag is low. ARM means powered but nothing is accepted. READ means only reads and the power-mode command are accepted. FULL means every class is accepted. DPD means deep power-down. The transitions are:
- OFF to ARM on the first edge with the inhibit flag high.
- ARM to FULL when both timers are done, or ARM to READ when only the operating-level timer is done.
- READ to FULL when the inhibit-side timer completes.
- READ or FULL to DPD on an accepted power-mode command.
- DPD back to FULL or READ on an accepted power-mode command, the target chosen by the inhibit-side timer.
- Any powered state to ARM when the operating-level timer is lost.
- Any state to OFF when the inhibit flag is low.

Top module: `pwrup_guard`

## Requirements
- R1: While `sup_inh_ok` is low, every output except `intr` reads 0 after the next clock edge, and a command strobe produces neither `cmd_acc` nor `cmd_ign`.
- R2: On the first clock edge with `sup_inh_ok` high, `lock_clr` pulses high for exactly one cycle, and `wel`, `wip` and `deep_pd` are 0 (standby, not deep power-down).
- R3: Count the clock edges from the first one where both supply flags are sampled high. `rd_en` rises on edge VSL_CYC+1 of that count, whether or not the inhibit-side delay has finished.
- R4: `wr_en` rises on edge max(PUW_CYC, VSL_CYC + d) + 1 after `sup_inh_ok` is first sampled high, where d is the number of edges by which `sup_min_ok` lags behind it. The rise happens only after both delays are done.
- R5: A delay timer whose flag is deasserted restarts from zero, so a glitch re-arms the full delay.
- R6: Command classes are encoded as `cmd_class` 0 = read, 1 = write-enable, 2 = modify (status write, program, erase), 3 = power-mode. ARM accepts nothing. READ accepts read and power-mode. FULL accepts all four classes. DPD accepts only power-mode.
- R7: Every strobe on `cmd_valid` while powered produces exactly one of `cmd_acc` or `cmd_ign`, one cycle later.
- R8: An accepted write-enable sets `wel`. An accepted modify clears it.
- R9: An accepted modify sets `wip`, and `op_done` clears it. While `wip` is 1, modify and power-mode commands are ignored.
- R10: An accepted power-mode command enters deep power-down (`deep_pd` = 1) from READ or FULL. Another accepted power-mode command releases it and restores the earlier permissions.
- R11: When `sup_inh_ok` falls, all operations are aborted on the next edge: `rd_en`, `wr_en`, `wel` and `wip` read 0.
- R12: If `wip` is 1 when `sup_inh_ok` is sampled low, `intr` is set. It stays set through reset and is cleared on the edge where the next power-up reaches FULL.
- R13: When `sup_min_ok` falls while powered, `rd_en` and `wr_en` drop two edges later. After the flag returns, both rise VSL_CYC+1 edges later if the inhibit-side delay already finished.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| sup_inh_ok | input | 1 | Supply above write-inhibit threshold; low holds block in reset |
| sup_min_ok | input | 1 | Supply above minimum operating level |
| cmd_valid | input | 1 | Decoded instruction strobe |
| cmd_class | input | 2 | Instruction class: 0 read, 1 write-enable, 2 modify, 3 power-mode |
| op_done | input | 1 | Program/erase finished, clears write-in-progress |
| rd_en | output | 1 | Read instructions permitted |
| wr_en | output | 1 | Write-enable and modify instructions permitted |
| deep_pd | output | 1 | Deep power-down mode active |
| wel | output | 1 | Write-enable latch |
| wip | output | 1 | Write in progress |
| lock_clr | output | 1 | One-cycle pulse loading lock registers with (0,0) |
| cmd_acc | output | 1 | Strobe of previous cycle accepted |
| cmd_ign | output | 1 | Strobe of previous cycle ignored |
| intr | output | 1 | Sticky: program/erase interrupted by power loss |

## Verification
The in-line assertions check properties on every cycle:
- each strobe yields exactly one answer;
- a rise of `rd_en` or `wr_en` is preceded by the matching timer completions;
- a timer's done flag clears after its flag drops;
- `wip` only rises while writes are permitted;
- deep power-down is entered only after a power-mode strobe;
- `intr` is cleared only on reaching FULL.

The exact edge on which permissions rise, for every ordering of the two supply crossings, can only be shown by the bench's sweep. The same holds for the full permission table per state, the re-arming after glitches, and the survival of `intr` across a reset.

// File: rtl/pwrup_guard_pkg.sv
package pwrup_guard_pkg;

    typedef enum logic [1:0] {
        CLS_READ   = 2'd0,
        CLS_WREN   = 2'd1,
        CLS_MODIFY = 2'd2,
        CLS_PWRDN  = 2'd3
    } cmd_cls_e;

    typedef enum logic [2:0] {
        ST_OFF,
        ST_ARM,
        ST_READ,
        ST_FULL,
        ST_DPD
    } pu_state_e;

endpackage

// File: rtl/pu_delay_timer.sv
module pu_delay_timer #(
    parameter int LEN = 16
) (
    input  logic clk,
    input  logic hold_n,
    input  logic run,
    output logic done
);
    localparam int CW = $clog2(LEN + 1);
    localparam logic [CW-1:0] LAST = CW'(LEN - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!hold_n || !run) begin
            cnt_q <= '0;
            done  <= 1'b0;
        end else if (cnt_q == LAST) begin
            done  <= 1'b1;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R5
    done_rearm_chk: assert property (@(posedge clk) disable iff (!hold_n)
        !run |=> !done);

    // R5
    done_hold_chk: assert property (@(posedge clk) disable iff (!hold_n)
        (done && run) |=> done);

endmodule

// File: rtl/pu_cmd_gate.sv
module pu_cmd_gate
    import pwrup_guard_pkg::*;
(
    input  pu_state_e state,
    input  cmd_cls_e  cls,
    input  logic      wip,
    output logic      ok
);
    always_comb begin
        ok = 1'b0;
        unique case (state)
            ST_READ: ok = (cls == CLS_READ) || (cls == CLS_PWRDN && !wip);
            ST_FULL: ok = (cls == CLS_READ) || (cls == CLS_WREN) ||
                          (cls == CLS_MODIFY && !wip) || (cls == CLS_PWRDN && !wip);
            ST_DPD:  ok = (cls == CLS_PWRDN);
            default: ok = 1'b0;
        endcase
    end
endmodule

// File: rtl/pu_seq.sv
module pu_seq
    import pwrup_guard_pkg::*;
(
    input  logic      clk,
    input  logic      inh_ok,
    input  logic      vsl_done,
    input  logic      puw_done,
    input  logic      cmd_valid,
    input  cmd_cls_e  cls,
    input  logic      cmd_ok,
    input  logic      op_done,
    output pu_state_e state,
    output logic      rd_en,
    output logic      wr_en,
    output logic      deep_pd,
    output logic      wel,
    output logic      wip,
    output logic      lock_clr,
    output logic      cmd_acc,
    output logic      cmd_ign,
    output logic      intr
);
    pu_state_e st_q, st_d;
    logic      pd_hit;
    logic      intr_q = 1'b0;

    assign pd_hit = cmd_valid && cmd_ok && (cls == CLS_PWRDN);

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_OFF:  st_d = ST_ARM;
            ST_ARM:  begin
                if (vsl_done && puw_done) st_d = ST_FULL;
                else if (vsl_done)        st_d = ST_READ;
            end
            ST_READ: begin
                if (!vsl_done)    st_d = ST_ARM;
                else if (pd_hit)  st_d = ST_DPD;
                else if (puw_done) st_d = ST_FULL;
            end
            ST_FULL: begin
                if (!vsl_done)   st_d = ST_ARM;
                else if (pd_hit) st_d = ST_DPD;
            end
            ST_DPD:  begin
                if (!vsl_done)   st_d = ST_ARM;
                else if (pd_hit) st_d = puw_done ? ST_FULL : ST_READ;
            end
            default: st_d = ST_OFF;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!inh_ok) st_q <= ST_OFF;
        else         st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (!inh_ok) begin
            lock_clr <= 1'b0;
            cmd_acc  <= 1'b0;
            cmd_ign  <= 1'b0;
            wel      <= 1'b0;
            wip      <= 1'b0;
        end else begin
            lock_clr <= (st_q == ST_OFF);
            cmd_acc  <= cmd_valid && cmd_ok;
            cmd_ign  <= cmd_valid && !cmd_ok;
            if (cmd_valid && cmd_ok && cls == CLS_WREN)        wel <= 1'b1;
            else if (cmd_valid && cmd_ok && cls == CLS_MODIFY) wel <= 1'b0;
            if (cmd_valid && cmd_ok && cls == CLS_MODIFY)      wip <= 1'b1;
            else if (op_done)                                  wip <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!inh_ok && wip)
            intr_q <= 1'b1;
        else if (inh_ok && st_d == ST_FULL &&
                 (st_q == ST_ARM || st_q == ST_READ))
            intr_q <= 1'b0;
    end

    assign state   = st_q;
    assign rd_en   = (st_q == ST_READ) || (st_q == ST_FULL);
    assign wr_en   = (st_q == ST_FULL);
    assign deep_pd = (st_q == ST_DPD);
    assign intr    = intr_q;

    // R3
    rd_after_vsl_chk: assert property (@(posedge clk) disable iff (!inh_ok)
        $rose(rd_en) |-> $past(vsl_done));

    // R4
    wr_after_both_chk: assert property (@(posedge clk) disable iff (!inh_ok)
        $rose(wr_en) |-> $past(vsl_done && puw_done));

    // R7
    one_answer_chk: assert property (@(posedge clk) disable iff (!inh_ok)
        cmd_valid |=> (cmd_acc ^ cmd_ign));

    // R2
    lock_pulse_chk: assert property (@(posedge clk) disable iff (!inh_ok)
        lock_clr |=> !lock_clr);

    // R9
    wip_source_chk: assert property (@(posedge clk) disable iff (!inh_ok)
        $rose(wip) |-> $past(wr_en));

    // R10
    dpd_entry_chk: assert property (@(posedge clk) disable iff (!inh_ok)
        $rose(deep_pd) |-> $past(cmd_valid && cls == CLS_PWRDN));

    // R12
    intr_clear_chk: assert property (@(posedge clk) disable iff (!inh_ok)
        $fell(intr) |-> wr_en);

endmodule

// File: rtl/pwrup_guard.sv
module pwrup_guard
    import pwrup_guard_pkg::*;
#(
    parameter int PUW_CYC = 1000,
    parameter int VSL_CYC = 200
) (
    input  logic       clk,
    input  logic       sup_inh_ok,
    input  logic       sup_min_ok,
    input  logic       cmd_valid,
    input  logic [1:0] cmd_class,
    input  logic       op_done,
    output logic       rd_en,
    output logic       wr_en,
    output logic       deep_pd,
    output logic       wel,
    output logic       wip,
    output logic       lock_clr,
    output logic       cmd_acc,
    output logic       cmd_ign,
    output logic       intr
);
    logic      puw_done, vsl_done, cmd_ok;
    pu_state_e state;
    cmd_cls_e  cls;

    assign cls = cmd_cls_e'(cmd_class);

    pu_delay_timer #(.LEN(PUW_CYC)) u_puw (
        .clk(clk), .hold_n(sup_inh_ok), .run(sup_inh_ok), .done(puw_done)
    );

    pu_delay_timer #(.LEN(VSL_CYC)) u_vsl (
        .clk(clk), .hold_n(sup_inh_ok), .run(sup_min_ok), .done(vsl_done)
    );

    pu_cmd_gate u_gate (
        .state(state), .cls(cls), .wip(wip), .ok(cmd_ok)
    );

    pu_seq u_seq (
        .clk(clk), .inh_ok(sup_inh_ok), .vsl_done(vsl_done), .puw_done(puw_done),
        .cmd_valid(cmd_valid), .cls(cls), .cmd_ok(cmd_ok), .op_done(op_done),
        .state(state), .rd_en(rd_en), .wr_en(wr_en), .deep_pd(deep_pd),
        .wel(wel), .wip(wip), .lock_clr(lock_clr), .cmd_acc(cmd_acc),
        .cmd_ign(cmd_ign), .intr(intr)
    );

    // R11
    abort_chk: assert property (@(posedge clk)
        $fell(sup_inh_ok) |=> (!rd_en && !wr_en && !wel && !wip));

endmodule

// File: tb/sim_pwrup_guard.sv
`timescale 1ns/1ps
module sim_pwrup_guard;
    localparam int PUW = 12;
    localparam int VSL = 3;

    logic clk = 1'b0;
    logic sup_inh_ok = 1'b0, sup_min_ok = 1'b0;
    logic cmd_valid = 1'b0, op_done = 1'b0;
    logic [1:0] cmd_class = 2'd0;
    logic rd_en, wr_en, deep_pd, wel, wip, lock_clr, cmd_acc, cmd_ign, intr;

    int n_cmp = 0, n_bad = 0;
    bit done_flag = 1'b0;

    always #2.5 clk = ~clk;

    pwrup_guard #(.PUW_CYC(PUW), .VSL_CYC(VSL)) u0 (
        .clk(clk), .sup_inh_ok(sup_inh_ok), .sup_min_ok(sup_min_ok),
        .cmd_valid(cmd_valid), .cmd_class(cmd_class), .op_done(op_done),
        .rd_en(rd_en), .wr_en(wr_en), .deep_pd(deep_pd), .wel(wel), .wip(wip),
        .lock_clr(lock_clr), .cmd_acc(cmd_acc), .cmd_ign(cmd_ign), .intr(intr)
    );

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic send(input logic [1:0] c);
        cmd_valid = 1'b1;
        cmd_class = c;
        tick();
        cmd_valid = 1'b0;
    endtask

    task automatic power_off();
        sup_inh_ok = 1'b0;
        sup_min_ok = 1'b0;
        tick();
        tick();
    endtask

    // count edges until rd_en and wr_en first read high
    task automatic count_up(output int fr, output int fw);
        fr = 0;
        fw = 0;
        for (int n = 1; n <= 40; n++) begin
            tick();
            if (rd_en && fr == 0) fr = n;
            if (wr_en && fw == 0) fw = n;
        end
    endtask

    initial begin
        #(5.0 * 150000);
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        if (!done_flag) $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        int fr, fw, exp_w;
        @(negedge clk);
        // R1: reset state and strobes ignored silently
        tick(); tick();
        chk("R1 rd_en", rd_en, 0);
        chk("R1 wr_en", wr_en, 0);
        chk("R1 lock_clr", lock_clr, 0);
        chk("R1 intr", intr, 0);
        sup_min_ok = 1'b1;
        send(2'd0);
        chk("R1 acc", cmd_acc, 0);
        chk("R1 ign", cmd_ign, 0);
        sup_min_ok = 1'b0;
        tick();

        // R3, R4, R2: sweep of lag between the two crossings
        for (int d = 0; d <= PUW + 2; d++) begin
            power_off();
            sup_inh_ok = 1'b1;
            if (d == 0) sup_min_ok = 1'b1;
            fr = 0;
            fw = 0;
            for (int n = 1; n <= 40; n++) begin
                tick();
                if (n == 1) begin
                    chk("R2 lock_clr", lock_clr, 1);
                    chk("R2 wel", wel, 0);
                    chk("R2 wip", wip, 0);
                    chk("R2 deep_pd", deep_pd, 0);
                end
                if (n == 2) chk("R2 lock_clr single", lock_clr, 0);
                if (rd_en && fr == 0) fr = n;
                if (wr_en && fw == 0) fw = n;
                if (n == d) sup_min_ok = 1'b1;
            end
            exp_w = ((PUW > d + VSL) ? PUW : d + VSL) + 1;
            chk("R3 rd_en edge", fr, d + VSL + 1);
            chk("R4 wr_en edge", fw, exp_w);
        end

        // R5: glitch on operating-level flag re-arms its delay
        power_off();
        sup_inh_ok = 1'b1;
        sup_min_ok = 1'b1;
        tick(); tick();
        sup_min_ok = 1'b0;
        tick();
        sup_min_ok = 1'b1;
        count_up(fr, fw);
        chk("R5 rd_en after glitch", fr, VSL + 1);

        // R6: permission table in ARM, READ
        power_off();
        sup_inh_ok = 1'b1;
        tick();
        for (int c = 0; c < 4; c++) begin
            send(2'(c));
            chk("R6 ARM ignores", cmd_ign, 1);
            chk("R7 ARM no acc", cmd_acc, 0);
        end
        sup_min_ok = 1'b1;
        for (int k = 0; k < VSL + 1; k++) tick();
        chk("R3 read state rd_en", rd_en, 1);
        chk("R4 read state wr_en", wr_en, 0);
        send(2'd0);
        chk("R6 READ accepts read", cmd_acc, 1);
        send(2'd1);
        chk("R6 READ ignores wren", cmd_ign, 1);
        chk("R6 wel untouched", wel, 0);
        send(2'd2);
        chk("R6 READ ignores modify", cmd_ign, 1);
        chk("R6 wip untouched", wip, 0);
        while (!wr_en) tick();

        // R8, R9, R10 in FULL
        send(2'd1);
        chk("R8 wren accepted", cmd_acc, 1);
        chk("R8 wel set", wel, 1);
        send(2'd2);
        chk("R8 modify accepted", cmd_acc, 1);
        chk("R8 wel cleared", wel, 0);
        chk("R9 wip set", wip, 1);
        send(2'd2);
        chk("R9 modify blocked by wip", cmd_ign, 1);
        send(2'd3);
        chk("R9 pwrdn blocked by wip", cmd_ign, 1);
        chk("R10 still standby", deep_pd, 0);
        op_done = 1'b1;
        tick();
        op_done = 1'b0;
        chk("R9 wip cleared", wip, 0);
        send(2'd3);
        chk("R10 dpd accepted", cmd_acc, 1);
        chk("R10 deep_pd", deep_pd, 1);
        chk("R10 rd_en off in dpd", rd_en, 0);
        send(2'd0);
        chk("R10 read ignored in dpd", cmd_ign, 1);
        send(2'd1);
        chk("R10 wren ignored in dpd", cmd_ign, 1);
        chk("R10 wel untouched", wel, 0);
        send(2'd3);
        chk("R10 release accepted", cmd_acc, 1);
        chk("R10 released", deep_pd, 0);
        chk("R10 wr_en restored", wr_en, 1);

        // R13: loss of operating-level flag
        sup_min_ok = 1'b0;
        tick();
        chk("R13 rd_en one edge", rd_en, 1);
        tick();
        chk("R13 rd_en dropped", rd_en, 0);
        chk("R13 wr_en dropped", wr_en, 0);
        sup_min_ok = 1'b1;
        count_up(fr, fw);
        chk("R13 rd_en back", fr, VSL + 1);
        chk("R13 wr_en back", fw, VSL + 1);

        // R11, R12: power loss during modify
        send(2'd1);
        send(2'd2);
        chk("R12 wip before loss", wip, 1);
        sup_inh_ok = 1'b0;
        sup_min_ok = 1'b0;
        tick();
        chk("R11 rd_en", rd_en, 0);
        chk("R11 wip", wip, 0);
        chk("R11 wel", wel, 0);
        chk("R12 intr set", intr, 1);
        tick();
        sup_inh_ok = 1'b1;
        sup_min_ok = 1'b1;
        for (int n = 1; n <= PUW + 1; n++) begin
            tick();
            if (n == PUW) chk("R12 intr held", intr, 1);
            if (n == PUW + 1) begin
                chk("R12 intr cleared", intr, 0);
                chk("R12 wr_en", wr_en, 1);
            end
        end
        power_off();
        chk("R12 no intr when idle", intr, 0);

        done_flag = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule